// File: doc/BRIEF.md
# Fractional and Integer 8x8 Multiplier

This unit multiplies two 8-bit operands and returns a 16-bit product split into a high byte and a low byte. The operand signedness is selected per operation: both unsigned, both signed, or a signed first operand with an unsigned second operand. Each of the three can also run in fractional form, where the product is shifted left by one place so that two Q1.7 numbers yield a Q1.15 result.

A caller presents the operands and a mode and pulses `start` for one cycle. Exactly two clock edges later the result bytes, a zero flag and a carry flag are updated and `done` pulses for one cycle. While an operation is in flight a further `start` is ignored. Results and flags hold their values until the next operation completes.

Top module: `mulfrac_unit`

## Requirements
- R1: After reset `prod_hi`, `prod_lo`, `flag_z`, `flag_c` and `done` are all zero.
- R2: With `mode[1:0]` = 2'b00 (or the spare code 2'b11) both operands are unsigned and the result is the low 16 bits of `op_a * op_b`.
- R3: With `mode[1:0]` = 2'b01 both operands are two's-complement signed and the result is the 16-bit two's-complement product.
- R4: With `mode[1:0]` = 2'b10 `op_a` is signed and `op_b` is unsigned; the result is the 16-bit two's-complement product.
- R5: With `mode[2]` = 1 (fractional) the result is the 16-bit product of R2 to R4 shifted left by one bit, bit 0 zero and the old bit 15 dropped; `mode[2]` = 0 gives the unshifted product.
- R6: `flag_c` equals bit 15 of the product before any fractional shift.
- R7: `flag_z` is 1 exactly when the final 16-bit result (after any shift) is zero.
- R8: A `start` accepted at clock edge k makes `done` high for the single cycle following edge k+1; result and flags change at that same edge k+1.
- R9: A `start` sampled while an operation is in flight (the edge right after an accepted start) is ignored and causes no further `done`; a held `start` is therefore accepted every second edge.
- R10: Between completions the result bytes and flags hold; operand or mode changes without an accepted `start` have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| mode | input | 3 | [2] fractional, [1:0] signedness: 00 u*u, 01 s*s, 10 s*u, 11 u*u |
| start | input | 1 | One-cycle request to begin an operation |
| prod_hi | output | 8 | Result bits 15..8 |
| prod_lo | output | 8 | Result bits 7..0 |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Bit 15 of the unshifted product |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a `start` that lands on the edge right after an accepted one, because a caller that waits for `done` never produces it. The stimulus holds `start` high across several consecutive edges while changing operands and mode every cycle, so the reference model must accept only every second request and the ignored operands must never appear in the result. Corner operands 0x00, 0x01, 0x7F, 0x80 and 0xFF in all eight mode codes reach the sign-extension and fractional-overflow cases, such as 0x80 times 0x80 signed, whose fractional result wraps to 0x8000 with carry clear.

// File: rtl/mulfrac_unit.sv
module mulfrac_unit #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic [2:0]     mode,
  input  logic           start,
  output logic [OPW-1:0] prod_hi,
  output logic [OPW-1:0] prod_lo,
  output logic           flag_z,
  output logic           flag_c,
  output logic           done
);
  localparam int PW = 2 * OPW;

  logic          busy;
  logic          frac_q;
  logic [PW-1:0] ea_q, eb_q;
  logic [PW-1:0] raw, res;
  logic          sgn_a, sgn_b, accept;

  assign accept = start && !busy;
  assign sgn_a  = (mode[1:0] == 2'b01) || (mode[1:0] == 2'b10);
  assign sgn_b  = (mode[1:0] == 2'b01);

  // operands widened to the product width so the low half of the
  // wrapped product equals the signed / unsigned product
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      frac_q <= 1'b0;
      ea_q   <= '0;
      eb_q   <= '0;
    end else begin
      busy <= accept;
      if (accept) begin
        frac_q <= mode[2];
        ea_q   <= {{OPW{sgn_a & op_a[OPW-1]}}, op_a};
        eb_q   <= {{OPW{sgn_b & op_b[OPW-1]}}, op_b};
      end
    end
  end

  assign raw = ea_q * eb_q;
  assign res = frac_q ? {raw[PW-2:0], 1'b0} : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_hi <= '0;
      prod_lo <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= busy;
      if (busy) begin
        prod_hi <= res[PW-1:OPW];
        prod_lo <= res[OPW-1:0];
        flag_z  <= (res == '0);
        flag_c  <= raw[PW-1];
      end
    end
  end
endmodule

module mulfrac_unit_chk #(
  parameter int OPW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     mode,
  input logic           start,
  input logic           busy,
  input logic [OPW-1:0] prod_hi,
  input logic [OPW-1:0] prod_lo,
  input logic           flag_z,
  input logic           flag_c,
  input logic           done
);
  assert_reset_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!done && !flag_z && !flag_c && prod_hi == '0 && prod_lo == '0));

  assert_frac_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(mode[2], 2) |-> prod_lo[0] == 1'b0);

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> (prod_hi == '0 && prod_lo == '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  assert_busy_to_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> !busy);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(flag_z) && $stable(flag_c)));
endmodule

bind mulfrac_unit mulfrac_unit_chk #(.OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .busy(busy),
  .prod_hi(prod_hi), .prod_lo(prod_lo), .flag_z(flag_z), .flag_c(flag_c),
  .done(done)
);

// File: tb/mulfrac_unit_tb.sv
module mulfrac_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [2:0] mode = '0;
  logic       start = 1'b0;
  logic [7:0] prod_hi, prod_lo;
  logic       flag_z, flag_c, done;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mulfrac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .mode(mode),
    .start(start), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .flag_z(flag_z), .flag_c(flag_c), .done(done)
  );

  // behavioural reference: pipeline of expected values
  bit          m_busy, m_done, m_z, m_c, p_z, p_c;
  logic [15:0] m_res, p_res;
  string       m_tag = "R2", p_tag = "R2";

  function automatic void ref_calc(input logic [7:0] a, input logic [7:0] b,
                                   input logic [2:0] md, output logic [15:0] r,
                                   output bit z, output bit c, output string tag);
    int ia, ib, p;
    logic [15:0] raw;
    ia  = (md[1:0] == 2'b01 || md[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    ib  = (md[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p   = ia * ib;
    raw = p[15:0];
    c   = raw[15];
    r   = md[2] ? (raw << 1) : raw;
    z   = (r == 16'h0);
    tag = md[2] ? "R5" : (md[1:0] == 2'b01) ? "R3" : (md[1:0] == 2'b10) ? "R4" : "R2";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_res <= '0; m_z <= 0; m_c <= 0;
    end else begin
      m_done <= m_busy;
      if (m_busy) begin
        m_res <= p_res; m_z <= p_z; m_c <= p_c; m_tag <= p_tag;
      end
      m_busy <= start && !m_busy;   // R9: request while busy is dropped
      if (start && !m_busy) ref_calc(op_a, op_b, mode, p_res, p_z, p_c, p_tag);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge (R8, R10 and per-mode product)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R8", "done", int'(done), int'(m_done));
      check(m_tag, "result", int'({prod_hi, prod_lo}), int'(m_res));
      check("R6", "flag_c", int'(flag_c), int'(m_c));
      check("R7", "flag_z", int'(flag_z), int'(m_z));
    end
  end

  task automatic issue(input logic [7:0] a, input logic [7:0] b, input logic [2:0] md);
    @(negedge clk);
    op_a = a; op_b = b; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = ~b; mode = ~md;  // R10: changes without start have no effect
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] corners [5];
    corners = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", int'(done), 0);
    check("R1", "result", int'({prod_hi, prod_lo}), 0);
    check("R1", "flags", int'({flag_z, flag_c}), 0);
    rst_n = 1'b1;
    // corner operands in every mode code (R2 R3 R4 R5 R6 R7)
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          issue(corners[i], corners[j], 3'(m));
    for (int k = 0; k < 400; k++)
      issue(8'($urandom), 8'($urandom), 3'($urandom));
    // R9: start held high with inputs changing every cycle
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      op_a = 8'($urandom); op_b = 8'($urandom); mode = 3'($urandom); start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    // R10: idle with wandering inputs
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      op_a = 8'($urandom); op_b = 8'($urandom); mode = 3'($urandom);
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule